// File: doc/BRIEF.md
# Mode-Selectable Channel Estimate Smoother

This block sits between a channel estimator and the channel RAM of a multi-antenna OFDM receiver. It accepts complex frequency-response estimates one subcarrier at a time, in subcarrier order, and produces one RAM write per estimate. When the packet uses a single antenna, each estimate is replaced by a weighted average of itself and its two neighbours across the subcarrier axis. This average uses shifts and adds only. When the packet uses either of the two multi-antenna schemes, each estimate is stored exactly as it arrived.

The estimator marks the first subcarrier of each symbol with a start flag and the final one with a last flag. The smoother needs the next subcarrier before it can finish the current one. For this reason every write lags its input by one sample, and the address on the write port is the index of the subcarrier being stored, not the index of the newest input. The stored path follows the same timing in every mode, so the RAM side never needs to know which mode is active.

Top module: `cest_smoother`

## Requirements
- R1: With mode code 2'b00 (single antenna), the stored value for subcarrier k is (H[k-1] + 2·H[k] + H[k+1] + 2) >>> 2. This is computed separately for the real and imaginary parts as signed two's complement, so halves round upward.
- R2: With mode codes 2'b01 (spatial multiplexing), 2'b10 (block-coded) and the spare code 2'b11, the stored value is the input estimate bit for bit. The mode is sampled together with each estimate.
- R3: For the first subcarrier of a symbol, the missing left neighbour is replaced by the centre value. For a subcarrier flagged last, the missing right neighbour is replaced by the centre value. A symbol of one subcarrier therefore stores its own value.
- R4: Every accepted estimate gives exactly one write. The write for subcarrier k appears on the clock edge that accepts subcarrier k+1 of the same symbol. For a subcarrier flagged last, the write appears one cycle after that subcarrier is accepted. No write appears at any other time.
- R5: The write address is the subcarrier index within the symbol. It is 0 for the sample that carries the start flag and rises by one for each later write of that symbol.
- R6: Write timing and addressing are the same in all modes.
- R7: A start flag that arrives while a subcarrier is still waiting for its right neighbour ends the old symbol. The waiting subcarrier is written as that symbol's last, on the same edge, and the new sample becomes subcarrier 0. A sample that follows a last-flagged subcarrier also starts a new symbol at address 0, even without a start flag.
- R8: During reset, wr_en, wr_addr, wr_re and wr_im are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An estimate is presented this cycle |
| in_sos | input | 1 | Estimate is subcarrier 0 of a new symbol |
| in_last | input | 1 | Estimate is the final subcarrier of its symbol |
| in_mode | input | 2 | 00 single antenna, 01 spatial multiplexing, 10 block-coded, 11 spare (stored raw) |
| in_re | input | DATA_W | Real part, signed |
| in_im | input | DATA_W | Imaginary part, signed |
| wr_en | output | 1 | RAM write strobe |
| wr_addr | output | ADDR_W | Subcarrier index being written |
| wr_re | output | DATA_W | Real part written |
| wr_im | output | DATA_W | Imaginary part written |

## Verification
The bench aims at the symbol edges. A design that shifted zeros in at an edge, instead of repeating the centre value, would store a visibly halved value there. It also checks a start flag that arrives while a subcarrier is still unfinished: a design that dropped or delayed that subcarrier would lose a RAM entry or write it at the wrong time or address. Rounding is probed with small negative and odd sums, where truncation or a logical shift gives a result that is off by one. Mixed-mode traffic with idle gaps checks that the stored raw values land on the same cycle and address the smoothed ones would, and that no write appears during gaps.

// File: rtl/cest_pkg.sv
package cest_pkg;

   typedef enum logic [1:0] {
      MODE_SINGLE  = 2'b00,
      MODE_SPMUX   = 2'b01,
      MODE_BLKCODE = 2'b10,
      MODE_SPARE   = 2'b11
   } cest_mode_e;

   localparam int NUM_PARTS = 2;

endpackage

// File: rtl/cest_tap3.sv
module cest_tap3 #(
   parameter int W        = 11,
   parameter bit ROUND_UP = 1'b1
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic [W-1:0] c,
   output logic [W-1:0] y
);
   localparam int SW = W + 2;

   logic signed [SW-1:0] sum;
   logic signed [W-1:0]  sa, sb, sc, sy;

   assign sa = $signed(a);
   assign sb = $signed(b);
   assign sc = $signed(c);

   generate
      if (ROUND_UP) begin : g_round
         assign sum = SW'(sa) + (SW'(sb) <<< 1) + SW'(sc) + SW'(2);
      end else begin : g_trunc
         assign sum = SW'(sa) + (SW'(sb) <<< 1) + SW'(sc);
      end
   endgenerate

   assign sy = W'(sum >>> 2);
   assign y  = sy;

   // A weighted mean never leaves the span of its inputs.
   logic signed [W-1:0] mn, mx;
   always_comb begin
      mn = sa;
      mx = sa;
      if (sb < mn) mn = sb;
      if (sc < mn) mn = sc;
      if (sb > mx) mx = sb;
      if (sc > mx) mx = sc;
      p_avg_in_range_r1: assert (sy >= mn && sy <= mx)
         else $error("smoothed value outside neighbour span");
   end

endmodule

// File: rtl/cest_window.sv
module cest_window
   import cest_pkg::*;
#(
   parameter int W  = 11,
   parameter int AW = 7
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          in_valid,
   input  logic                          in_sos,
   input  logic                          in_last,
   input  logic [1:0]                    in_mode,
   input  logic [NUM_PARTS-1:0][W-1:0]   in_d,
   output logic                          emit,
   output logic [AW-1:0]                 emit_addr,
   output logic [NUM_PARTS-1:0][W-1:0]   left,
   output logic [NUM_PARTS-1:0][W-1:0]   mid,
   output logic [NUM_PARTS-1:0][W-1:0]   right,
   output logic [1:0]                    mid_mode,
   output logic                          flush_pend
);
   logic                        have_q, first_q, last_q;
   cest_mode_e                  mode_q;
   logic [NUM_PARTS-1:0][W-1:0] cen_q, prv_q;
   logic [AW-1:0]               idx_q;
   logic                        new_sym;

   always_comb begin
      flush_pend = have_q & last_q;
      new_sym    = in_valid & (in_sos | ~have_q | last_q);
      emit       = have_q & (last_q | in_valid);
      emit_addr  = idx_q;
      mid        = cen_q;
      mid_mode   = mode_q;
      left       = first_q ? cen_q : prv_q;
      right      = (last_q | new_sym) ? cen_q : in_d;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         have_q  <= 1'b0;
         first_q <= 1'b0;
         last_q  <= 1'b0;
         mode_q  <= MODE_SINGLE;
         cen_q   <= '0;
         prv_q   <= '0;
         idx_q   <= '0;
      end else begin
         if (new_sym)   idx_q <= '0;
         else if (emit) idx_q <= idx_q + 1'b1;

         if (in_valid) begin
            prv_q   <= new_sym ? '0 : cen_q;
            cen_q   <= in_d;
            first_q <= new_sym;
            last_q  <= in_last;
            mode_q  <= cest_mode_e'(in_mode);
            have_q  <= 1'b1;
         end else if (flush_pend) begin
            have_q  <= 1'b0;
            last_q  <= 1'b0;
         end
      end
   end

   // After a last subcarrier is drained the window is empty or holds a fresh symbol start.
   p_flush_drains_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (have_q && last_q) |=> (!have_q || first_q));

endmodule

// File: rtl/cest_smoother.sv
module cest_smoother
   import cest_pkg::*;
#(
   parameter int DATA_W        = 11,
   parameter int ADDR_W        = 7,
   parameter bit ROUND_HALF_UP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_sos,
   input  logic              in_last,
   input  logic [1:0]        in_mode,
   input  logic [DATA_W-1:0] in_re,
   input  logic [DATA_W-1:0] in_im,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_re,
   output logic [DATA_W-1:0] wr_im
);
   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("DATA_W must be at least 2");
      end
      if (ADDR_W < 1) begin : g_bad_addr
         $error("ADDR_W must be at least 1");
      end
   endgenerate

   logic [NUM_PARTS-1:0][DATA_W-1:0] in_d, left, mid, right, smooth, sel;
   logic                             emit, flush_pend;
   logic [ADDR_W-1:0]                emit_addr;
   logic [1:0]                       mid_mode;

   assign in_d = {in_im, in_re};

   cest_window #(.W(DATA_W), .AW(ADDR_W)) u_win (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .in_sos     (in_sos),
      .in_last    (in_last),
      .in_mode    (in_mode),
      .in_d       (in_d),
      .emit       (emit),
      .emit_addr  (emit_addr),
      .left       (left),
      .mid        (mid),
      .right      (right),
      .mid_mode   (mid_mode),
      .flush_pend (flush_pend)
   );

   generate
      for (genvar g = 0; g < NUM_PARTS; g++) begin : g_part
         cest_tap3 #(.W(DATA_W), .ROUND_UP(ROUND_HALF_UP)) u_tap (
            .a (left[g]),
            .b (mid[g]),
            .c (right[g]),
            .y (smooth[g])
         );
      end
   endgenerate

   assign sel = (mid_mode == MODE_SINGLE) ? smooth : mid;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_en   <= 1'b0;
         wr_addr <= '0;
         wr_re   <= '0;
         wr_im   <= '0;
      end else begin
         wr_en <= emit;
         if (emit) begin
            wr_addr <= emit_addr;
            wr_re   <= sel[0];
            wr_im   <= sel[1];
         end
      end
   end

   p_last_written_r3: assert property (@(posedge clk) disable iff (!rst_n)
      flush_pend |=> wr_en);

   p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_valid && !flush_pend) |=> !wr_en);

   p_bypass_raw_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (emit && mid_mode != MODE_SINGLE) |=>
         (wr_re == $past(mid[0]) && wr_im == $past(mid[1])));

   p_addr_seq_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && $past(wr_en) && wr_addr != '0) |->
         (wr_addr == ADDR_W'($past(wr_addr) + 1'b1)));

endmodule

// File: tb/sim_cest_smoother.sv
module sim_cest_smoother;
   localparam int DW = 11;
   localparam int AW = 7;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0, in_sos = 1'b0, in_last = 1'b0;
   logic [1:0]    in_mode = 2'b00;
   logic [DW-1:0] in_re = '0, in_im = '0;
   logic          wr_en;
   logic [AW-1:0] wr_addr;
   logic [DW-1:0] wr_re, wr_im;

   always #4 clk = ~clk;

   cest_smoother #(.DATA_W(DW), .ADDR_W(AW)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sos(in_sos),
      .in_last(in_last), .in_mode(in_mode), .in_re(in_re), .in_im(in_im),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_re(wr_re), .wr_im(wr_im));

   typedef struct {
      int    addr;
      int    re;
      int    im;
      int    at;
      string dtag;
      string ttag;
   } exp_t;

   exp_t q[$];
   exp_t pend_e;
   bit   pend_v = 0;
   int   cyc = 0;
   int   checks = 0;
   int   errors = 0;
   bit   mon_on = 0;
   int   sre[64];
   int   sim[64];

   always @(posedge clk) cyc <= cyc + 1;

   function automatic int sm(input int a, input int b, input int c);
      return (a + 2 * b + c + 2) >>> 2;
   endfunction

   task automatic chk(input bit ok, input string tag, input string what,
                      input int got, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual %0d expected %0d", tag, what, got, exp);
      end
   endtask

   // Expected entry for subcarrier i of a symbol of n samples.
   function automatic exp_t make(input int i, input int n, input int mode);
      exp_t e;
      int lr, rr, li, ri;
      lr = (i == 0) ? sre[i] : sre[i-1];
      li = (i == 0) ? sim[i] : sim[i-1];
      rr = (i == n-1) ? sre[i] : sre[i+1];
      ri = (i == n-1) ? sim[i] : sim[i+1];
      e.addr = i;
      if (mode == 0) begin
         e.re = sm(lr, sre[i], rr);
         e.im = sm(li, sim[i], ri);
         e.dtag = (i == 0 || i == n-1) ? "R3" : "R1";
         e.ttag = "R4";
      end else begin
         e.re = sre[i];
         e.im = sim[i];
         e.dtag = "R2";
         e.ttag = "R6";
      end
      e.at = 0;
      return e;
   endfunction

   task automatic send_sym(input int n, input int mode, input bit use_last,
                           input bit use_sos, input int gap);
      int   t;
      exp_t e;
      for (int i = 0; i < n; i++) begin
         if (gap > 0) begin
            int g;
            g = $urandom_range(0, gap);
            for (int k = 0; k < g; k++) @(negedge clk);
         end
         @(negedge clk);
         in_valid = 1'b1;
         in_sos   = (i == 0) && use_sos;
         in_last  = (i == n-1) && use_last;
         in_mode  = 2'(mode);
         in_re    = DW'(sre[i]);
         in_im    = DW'(sim[i]);
         @(posedge clk);
         #1;
         t = cyc;
         in_valid = 1'b0;
         in_sos   = 1'b0;
         in_last  = 1'b0;
         if (pend_v) begin
            pend_e.at = t;
            if (i == 0) pend_e.ttag = "R7";
            q.push_back(pend_e);
            pend_v = 0;
         end
         e = make(i, n, mode);
         if (i == n-1 && use_last) begin
            e.at = t + 1;
            q.push_back(e);
         end else if (i == n-1) begin
            pend_e = e;
            pend_v = 1;
         end else begin
            pend_e = e;
            pend_v = 1;
         end
      end
   endtask

   task automatic fill_rand(input int n);
      for (int i = 0; i < n; i++) begin
         sre[i] = int'($urandom_range(0, 2047)) - 1024;
         sim[i] = int'($urandom_range(0, 2047)) - 1024;
      end
   endtask

   // Monitor: every write is matched against the next expected entry.
   always @(negedge clk) begin
      if (mon_on) begin
         if (wr_en) begin
            if (q.size() == 0) begin
               chk(1'b0, "R4", "unexpected write at addr", int'(wr_addr), -1);
            end else begin
               exp_t e;
               e = q.pop_front();
               chk(cyc == e.at, e.ttag, "write cycle", cyc, e.at);
               chk(int'(wr_addr) == e.addr, "R5", "write addr", int'(wr_addr), e.addr);
               chk($signed(wr_re) == e.re, e.dtag, "real part", int'($signed(wr_re)), e.re);
               chk($signed(wr_im) == e.im, e.dtag, "imag part", int'($signed(wr_im)), e.im);
            end
         end else if (q.size() > 0 && q[0].at < cyc) begin
            exp_t e;
            e = q.pop_front();
            chk(1'b0, e.ttag, "missing write for addr", -1, e.addr);
         end
      end
   end

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_C0DE));
      // Reset state (R8)
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk(wr_en == 1'b0, "R8", "wr_en in reset", int'(wr_en), 0);
         chk(wr_addr == '0 && wr_re == '0 && wr_im == '0, "R8", "outputs in reset",
             int'(wr_addr) + int'(wr_re) + int'(wr_im), 0);
      end
      rst_n = 1'b1;
      mon_on = 1'b1;

      // Rounding probes, single-antenna mode (R1)
      sre[0] = 1;  sre[1] = 0;  sre[2] = 1;  sre[3] = -1; sre[4] = 0;
      sim[0] = -1; sim[1] = 0;  sim[2] = -1; sim[3] = 2;  sim[4] = 1;
      send_sym(5, 0, 1'b1, 1'b1, 0);

      // Full-scale values (R1, R3)
      sre[0] = 1023;  sre[1] = 1023;  sre[2] = 1023;
      sim[0] = -1024; sim[1] = -1024; sim[2] = -1024;
      send_sym(3, 0, 1'b1, 1'b1, 0);

      // Single-subcarrier symbol stores itself (R3)
      sre[0] = -7; sim[0] = 333;
      send_sym(1, 0, 1'b1, 1'b1, 0);

      // Raw storage in each bypass code (R2, R6)
      for (int m = 1; m < 4; m++) begin
         fill_rand(6);
         send_sym(6, m, 1'b1, 1'b1, 1);
      end

      // Start flag ends a symbol lacking its last flag (R7)
      fill_rand(5);
      send_sym(5, 0, 1'b0, 1'b1, 0);
      fill_rand(3);
      send_sym(3, 0, 1'b1, 1'b1, 0);
      // Sample after a last starts a symbol without a start flag (R7)
      fill_rand(4);
      send_sym(4, 1, 1'b1, 1'b0, 0);
      fill_rand(4);
      send_sym(4, 0, 1'b0, 1'b1, 0);
      fill_rand(2);
      send_sym(2, 2, 1'b1, 1'b1, 1);

      // Constrained random traffic
      for (int s = 0; s < 40; s++) begin
         int n, m;
         bit l;
         n = $urandom_range(1, 24);
         m = $urandom_range(0, 3);
         l = ($urandom_range(0, 3) != 0);
         fill_rand(n);
         send_sym(n, m, l, 1'b1, 2);
      end
      fill_rand(8);
      send_sym(8, 0, 1'b1, 1'b1, 0);

      repeat (6) @(negedge clk);
      chk(q.size() == 0 && !pend_v, "R4", "outstanding expected writes", q.size(), 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule